// File: doc/BRIEF.md
# Smart-Card Line Monitor Session Sequencer

This block sits at the top of a passive monitor that listens to the link between a card reader and a smart card. It follows the card's reset line and the stream of characters seen by a receiver, and it steps through five session phases. These are: held in reset, waiting for the answer-to-reset, inside the answer-to-reset, waiting for a command exchange, and inside a command exchange. A separate answer-to-reset parser decodes the card's opening bytes. This sequencer forwards those bytes to it, restarts it whenever the reset line is released, and applies the new character timing when the parser reports that it has finished.

An inactivity timer counts elementary time units (one pulse on `etu_tick` per unit). When the line stays silent for the full waiting time, the timer marks the end of an exchange. Every observed byte is written into fixed-size upload packets. Each packet starts with a reserved header area, and the packet is closed either when it is full or when the inactivity timer expires. The closing strobe carries the packet length and two header flags: one records that a reset release happened, the other records that the packet was closed by a timeout.

Top module: `cardmon_session_ctrl`

## Requirements
- R1: `phase` encodes the session phase as 0 reset, 1 waiting for the answer-to-reset, 2 inside it, 3 waiting for a command, 4 inside a command. While `phase` is 0, `rx_enable` is low and `rx_clear` is high. A low level on `card_rst_pin` that persists past the filter drives `phase` to 0.
- R2: `card_rst_pin` passes through a two-flop synchronizer and a filter. A level change shorter than `FILT_LEN` clock cycles has no effect on `phase` and produces no `parser_restart` pulse.
- R3: A filtered rising edge of the reset pin moves `phase` to 1 and gives exactly one single-cycle `parser_restart` pulse. It sets header flag bit 0 (reset release) for the next packet closed, and it loads the waiting time with `INIT_WT` (default 9600) units.
- R4: A byte received while `phase` is 1 or 2 is presented on `atr_byte_valid`/`atr_byte` in the same cycle, and `phase` becomes 2. In any other phase, `atr_byte_valid` stays low.
- R5: `atr_done` while `phase` is 1 or 2 moves `phase` to 3 and runs a timing-change sequence. In the first cycle the receiver is disabled (`rx_enable` low) and cleared (`rx_clear` high). In the second cycle `ratio_load` is high with the receiver still disabled. In the third cycle the receiver is enabled again. The inactivity timer then restarts with `atr_wtime` units.
- R6: A byte received while `phase` is 3 or 4 moves `phase` to 4.
- R7: Every accepted byte, including answer-to-reset bytes, is written on `pkt_we` at address `HDR_BYTES` plus the number of payload bytes already in the packet. When the payload reaches `PKT_BYTES - HDR_BYTES`, `pkt_flush` pulses with `pkt_len` equal to `PKT_BYTES`.
- R8: The inactivity counter reloads on every received byte and on each new waiting time. It counts down once per `etu_tick`. After exactly N ticks with no byte, it closes a partly filled packet with header flag bit 1 (timeout) set and `pkt_len` equal to `HDR_BYTES` plus the payload count, and `phase` becomes 3.
- R9: Header flags are cleared once a packet is closed, so the next packet carries only flags raised after that point.
- R10: A byte that arrives while no packet is open and `buf_avail` is low is dropped: no write occurs and `lost_count` increments by one.
- R11: An expiry while no packet is open emits no `pkt_flush`, but `phase` still becomes 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_rst_pin | input | 1 | Card reset line level, asynchronous |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_data | input | 8 | Received character |
| etu_tick | input | 1 | One pulse per elementary time unit |
| atr_done | input | 1 | Parser reports the answer-to-reset complete |
| atr_wtime | input | WT_W | Waiting time computed by the parser |
| buf_avail | input | 1 | A free upload packet buffer exists |
| phase | output | 3 | Current session phase |
| rx_enable | output | 1 | Receiver enable |
| rx_clear | output | 1 | Receiver clear |
| ratio_load | output | 1 | Load the new clock-to-unit ratio into the receiver |
| parser_restart | output | 1 | Restart the parser to its default timing values |
| atr_byte_valid | output | 1 | Byte forwarded to the parser |
| atr_byte | output | 8 | Forwarded byte |
| pkt_we | output | 1 | Packet byte write strobe |
| pkt_addr | output | $clog2(PKT_BYTES) | Byte position within the packet |
| pkt_data | output | 8 | Packet byte |
| pkt_flush | output | 1 | Packet closed |
| pkt_len | output | $clog2(PKT_BYTES+1) | Length of the closed packet including the header |
| pkt_flags | output | 2 | Header flags of the closed packet |
| lost_count | output | LOST_W | Saturating count of dropped bytes |

## Verification
The bench checks the inactivity timer to the exact tick. A counter that is off by one would close the packet one unit early or late. A counter that ignored reloads would close a packet in the middle of a burst of bytes. The bench also sends glitches shorter than the filter window, which a missing filter would turn into a spurious restart. It fills packets to capacity across random gaps in buffer availability, where a wrong address or a missed drop would shift every later byte. It expires the timer with nothing pending, where a sloppy design would emit an empty packet. Finally, it follows the timing-change sequence cycle by cycle, so re-enabling the receiver before the ratio is loaded is caught.

// File: rtl/cardmon_pkg.sv
package cardmon_pkg;

   typedef enum logic [2:0] {
      PH_RESET    = 3'd0,
      PH_WAIT_ATR = 3'd1,
      PH_IN_ATR   = 3'd2,
      PH_WAIT_CMD = 3'd3,
      PH_IN_CMD   = 3'd4
   } phase_e;

   localparam int FLAG_W = 2;
   localparam logic [FLAG_W-1:0] FLAG_RST_REL = 2'b01;
   localparam logic [FLAG_W-1:0] FLAG_TMO     = 2'b10;

endpackage

// File: rtl/cardmon_pin_filter.sv
module cardmon_pin_filter #(
   parameter int FILT_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic lvl,
   output logic rise
);
   logic [1:0] sync_q;
   logic       lvl_q;
   logic       lvl_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q  <= 2'b00;
         lvl_d_q <= 1'b0;
      end else begin
         sync_q  <= {sync_q[0], pin_async};
         lvl_d_q <= lvl_q;
      end
   end

   generate
      if (FILT_LEN == 0) begin : g_nofilt
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl_q <= 1'b0;
            else        lvl_q <= sync_q[1];
         end
      end else begin : g_filt
         localparam int CW = $clog2(FILT_LEN + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lvl_q <= 1'b0;
               cnt_q <= '0;
            end else if (sync_q[1] == lvl_q) begin
               cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
               lvl_q <= sync_q[1];
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

   assign lvl  = lvl_q;
   assign rise = lvl_q & ~lvl_d_q;
endmodule

// File: rtl/cardmon_wait_timer.sv
module cardmon_wait_timer #(
   parameter int WT_W = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            load,
   input  logic [WT_W-1:0] load_val,
   input  logic            tick,
   output logic            expire
);
   logic [WT_W-1:0] cnt_q;
   logic            armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (clear) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (load) begin
         cnt_q   <= load_val;
         armed_q <= |load_val;
      end else if (armed_q && tick) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == WT_W'(1)) armed_q <= 1'b0;
      end
   end

   assign expire = armed_q & tick & (cnt_q == WT_W'(1)) & ~load & ~clear;
endmodule

// File: rtl/cardmon_packer.sv
module cardmon_packer
   import cardmon_pkg::*;
#(
   parameter int PKT_BYTES = 64,
   parameter int HDR_BYTES = 4,
   parameter int LOST_W    = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           byte_valid,
   input  logic [7:0]                     byte_data,
   input  logic                           buf_avail,
   input  logic                           set_rel,
   input  logic                           expire,
   output logic                           we,
   output logic [$clog2(PKT_BYTES)-1:0]   addr,
   output logic [7:0]                     data,
   output logic                           flush,
   output logic [$clog2(PKT_BYTES+1)-1:0] len,
   output logic [FLAG_W-1:0]              flags,
   output logic [LOST_W-1:0]              lost_cnt
);
   localparam int PAY = PKT_BYTES - HDR_BYTES;
   localparam int AW  = $clog2(PKT_BYTES);
   localparam int LW  = $clog2(PKT_BYTES + 1);
   localparam int FW  = $clog2(PAY + 1);

   logic [FW-1:0]     fill_q;
   logic              have_q;
   logic [FLAG_W-1:0] hdr_q;
   logic              take, drop, full;
   logic [FLAG_W-1:0] new_rel;

   assign take    = byte_valid & (have_q | buf_avail);
   assign drop    = byte_valid & ~have_q & ~buf_avail;
   assign full    = take & (fill_q == FW'(PAY - 1));
   assign new_rel = set_rel ? FLAG_RST_REL : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we       <= 1'b0;
         addr     <= '0;
         data     <= '0;
         flush    <= 1'b0;
         len      <= '0;
         flags    <= '0;
         fill_q   <= '0;
         have_q   <= 1'b0;
         hdr_q    <= '0;
         lost_cnt <= '0;
      end else begin
         we    <= take;
         flush <= 1'b0;
         if (take) begin
            addr <= AW'(HDR_BYTES + int'(fill_q));
            data <= byte_data;
         end
         if (drop && lost_cnt != '1) lost_cnt <= lost_cnt + 1'b1;
         if (full) begin
            flush  <= 1'b1;
            len    <= LW'(PKT_BYTES);
            flags  <= hdr_q;
            fill_q <= '0;
            have_q <= 1'b0;
            hdr_q  <= new_rel;
         end else if (expire && have_q) begin
            flush  <= 1'b1;
            len    <= LW'(HDR_BYTES + int'(fill_q));
            flags  <= hdr_q | FLAG_TMO;
            fill_q <= '0;
            have_q <= 1'b0;
            hdr_q  <= new_rel;
         end else begin
            if (take) begin
               fill_q <= fill_q + 1'b1;
               have_q <= 1'b1;
            end
            hdr_q <= hdr_q | new_rel;
         end
      end
   end
endmodule

// File: rtl/cardmon_session_ctrl.sv
module cardmon_session_ctrl
   import cardmon_pkg::*;
#(
   parameter int PKT_BYTES = 64,
   parameter int HDR_BYTES = 4,
   parameter int FILT_LEN  = 4,
   parameter int WT_W      = 24,
   parameter int INIT_WT   = 9600,
   parameter int LOST_W    = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           card_rst_pin,
   input  logic                           rx_valid,
   input  logic [7:0]                     rx_data,
   input  logic                           etu_tick,
   input  logic                           atr_done,
   input  logic [WT_W-1:0]                atr_wtime,
   input  logic                           buf_avail,
   output logic [2:0]                     phase,
   output logic                           rx_enable,
   output logic                           rx_clear,
   output logic                           ratio_load,
   output logic                           parser_restart,
   output logic                           atr_byte_valid,
   output logic [7:0]                     atr_byte,
   output logic                           pkt_we,
   output logic [$clog2(PKT_BYTES)-1:0]   pkt_addr,
   output logic [7:0]                     pkt_data,
   output logic                           pkt_flush,
   output logic [$clog2(PKT_BYTES+1)-1:0] pkt_len,
   output logic [FLAG_W-1:0]              pkt_flags,
   output logic [LOST_W-1:0]              lost_count
);
   generate
      if (HDR_BYTES < 1 || HDR_BYTES >= PKT_BYTES) begin : g_bad_hdr
         $error("HDR_BYTES must be at least 1 and below PKT_BYTES");
      end
      if (WT_W < 2 || WT_W > 30 || INIT_WT >= (1 << WT_W)) begin : g_bad_wt
         $error("WT_W out of range or too narrow for INIT_WT");
      end
      if (FILT_LEN < 0) begin : g_bad_filt
         $error("FILT_LEN must not be negative");
      end
   endgenerate

   logic            pin_lvl, pin_rise;
   logic            tmr_expire, tmr_load;
   logic [WT_W-1:0] tmr_val;
   phase_e          ph_q;
   logic [1:0]      step_q;
   logic [WT_W-1:0] wt_cur_q;
   logic            in_atr_ph, in_cmd_ph;

   cardmon_pin_filter #(.FILT_LEN(FILT_LEN)) u_pin (
      .clk(clk), .rst_n(rst_n), .pin_async(card_rst_pin),
      .lvl(pin_lvl), .rise(pin_rise)
   );

   assign in_atr_ph = (ph_q == PH_WAIT_ATR) || (ph_q == PH_IN_ATR);
   assign in_cmd_ph = (ph_q == PH_WAIT_CMD) || (ph_q == PH_IN_CMD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= PH_RESET;
         step_q   <= 2'd0;
         wt_cur_q <= WT_W'(INIT_WT);
      end else if (!pin_lvl) begin
         ph_q   <= PH_RESET;
         step_q <= 2'd0;
      end else if (pin_rise) begin
         ph_q     <= PH_WAIT_ATR;
         step_q   <= 2'd0;
         wt_cur_q <= WT_W'(INIT_WT);
      end else begin
         if (step_q != 2'd0) step_q <= step_q + 2'd1;
         if (step_q == 2'd3) wt_cur_q <= atr_wtime;
         if (tmr_expire)                  ph_q <= PH_WAIT_CMD;
         else if (rx_valid && in_atr_ph)  ph_q <= PH_IN_ATR;
         else if (rx_valid && in_cmd_ph)  ph_q <= PH_IN_CMD;
         if (atr_done && in_atr_ph) begin
            ph_q   <= PH_WAIT_CMD;
            step_q <= 2'd1;
         end
      end
   end

   assign tmr_load = pin_rise | (pin_lvl & (step_q == 2'd3))
                   | (pin_lvl & rx_valid & (ph_q != PH_RESET));
   assign tmr_val  = pin_rise ? WT_W'(INIT_WT)
                   : (step_q == 2'd3) ? atr_wtime : wt_cur_q;

   cardmon_wait_timer #(.WT_W(WT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clear(~pin_lvl), .load(tmr_load),
      .load_val(tmr_val), .tick(etu_tick), .expire(tmr_expire)
   );

   cardmon_packer #(.PKT_BYTES(PKT_BYTES), .HDR_BYTES(HDR_BYTES), .LOST_W(LOST_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .byte_valid(rx_valid), .byte_data(rx_data),
      .buf_avail(buf_avail), .set_rel(pin_rise), .expire(tmr_expire),
      .we(pkt_we), .addr(pkt_addr), .data(pkt_data), .flush(pkt_flush),
      .len(pkt_len), .flags(pkt_flags), .lost_cnt(lost_count)
   );

   assign phase          = ph_q;
   assign rx_enable      = (ph_q != PH_RESET) && (step_q != 2'd1) && (step_q != 2'd2);
   assign rx_clear       = (ph_q == PH_RESET) || (step_q == 2'd1);
   assign ratio_load     = (step_q == 2'd2);
   assign parser_restart = pin_rise;
   assign atr_byte_valid = rx_valid & in_atr_ph;
   assign atr_byte       = rx_data;
endmodule

// File: rtl/cardmon_session_ctrl_chk.sv
module cardmon_session_ctrl_chk #(
   parameter int PKT_BYTES = 64,
   parameter int HDR_BYTES = 4,
   parameter int LOST_W    = 16
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic [2:0]                     phase,
   input logic                           rx_enable,
   input logic                           rx_clear,
   input logic                           ratio_load,
   input logic                           parser_restart,
   input logic                           atr_byte_valid,
   input logic                           pkt_we,
   input logic [$clog2(PKT_BYTES)-1:0]   pkt_addr,
   input logic                           pkt_flush,
   input logic [$clog2(PKT_BYTES+1)-1:0] pkt_len,
   input logic [1:0]                     pkt_flags,
   input logic [LOST_W-1:0]              lost_count
);
   p_reset_rx_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == 3'd0) |-> (!rx_enable && rx_clear));

   p_restart_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      parser_restart |=> !parser_restart);

   p_fwd_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      atr_byte_valid |-> (phase == 3'd1 || phase == 3'd2));

   p_load_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_load |-> (!rx_enable && $past(rx_clear)));

   p_enable_after_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_load |=> (rx_enable || phase == 3'd0));

   p_write_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_we |-> (int'(pkt_addr) >= HDR_BYTES && int'(pkt_addr) < PKT_BYTES));

   p_flush_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_flush |-> (int'(pkt_len) > HDR_BYTES && int'(pkt_len) <= PKT_BYTES));

   p_timeout_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_flush && pkt_flags[1]) |-> (phase == 3'd3));

   p_drop_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lost_count) |-> !pkt_we);
endmodule

bind cardmon_session_ctrl cardmon_session_ctrl_chk #(
   .PKT_BYTES(PKT_BYTES), .HDR_BYTES(HDR_BYTES), .LOST_W(LOST_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .phase(phase), .rx_enable(rx_enable),
   .rx_clear(rx_clear), .ratio_load(ratio_load), .parser_restart(parser_restart),
   .atr_byte_valid(atr_byte_valid), .pkt_we(pkt_we), .pkt_addr(pkt_addr),
   .pkt_flush(pkt_flush), .pkt_len(pkt_len), .pkt_flags(pkt_flags),
   .lost_count(lost_count)
);

// File: tb/cardmon_session_ctrl_test.sv
module cardmon_session_ctrl_test;
   localparam int PKT = 64;
   localparam int HDR = 4;
   localparam int PAY = PKT - HDR;
   localparam int WTA = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        card_rst_pin = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic        etu_tick = 1'b0;
   logic        atr_done = 1'b0;
   logic [23:0] atr_wtime = 24'(WTA);
   logic        buf_avail = 1'b1;
   logic [2:0]  phase;
   logic        rx_enable, rx_clear, ratio_load, parser_restart, atr_byte_valid;
   logic [7:0]  atr_byte, pkt_data;
   logic        pkt_we, pkt_flush;
   logic [5:0]  pkt_addr;
   logic [6:0]  pkt_len;
   logic [1:0]  pkt_flags;
   logic [15:0] lost_count;

   int checks = 0;
   int errors = 0;
   int restarts = 0;
   int m_fill = 0;
   bit m_have = 0;
   int m_flags = 0;
   int m_lost = 0;

   always #4 clk = ~clk;

   cardmon_session_ctrl uut (
      .clk(clk), .rst_n(rst_n), .card_rst_pin(card_rst_pin), .rx_valid(rx_valid),
      .rx_data(rx_data), .etu_tick(etu_tick), .atr_done(atr_done),
      .atr_wtime(atr_wtime), .buf_avail(buf_avail), .phase(phase),
      .rx_enable(rx_enable), .rx_clear(rx_clear), .ratio_load(ratio_load),
      .parser_restart(parser_restart), .atr_byte_valid(atr_byte_valid),
      .atr_byte(atr_byte), .pkt_we(pkt_we), .pkt_addr(pkt_addr),
      .pkt_data(pkt_data), .pkt_flush(pkt_flush), .pkt_len(pkt_len),
      .pkt_flags(pkt_flags), .lost_count(lost_count)
   );

   always @(posedge clk) if (parser_restart) restarts++;

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int exp_timeout_len(int fill);
      return HDR + fill;
   endfunction

   task automatic send_byte(logic [7:0] b, bit fwd);
      bit take;
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = b;
      #1;
      chk("R4", "parser forward", int'(atr_byte_valid), int'(fwd));
      if (fwd) chk("R4", "parser byte", int'(atr_byte), int'(b));
      take = m_have || buf_avail;
      @(negedge clk);
      rx_valid = 1'b0;
      chk("R7", "write strobe", int'(pkt_we), int'(take));
      if (take) begin
         chk("R7", "write addr", int'(pkt_addr), HDR + m_fill);
         chk("R7", "write data", int'(pkt_data), int'(b));
         m_fill++;
         m_have = 1;
         if (m_fill == PAY) begin
            chk("R7", "full flush", int'(pkt_flush), 1);
            chk("R7", "full len", int'(pkt_len), PKT);
            chk("R9", "full flags", int'(pkt_flags), m_flags);
            m_fill = 0; m_have = 0; m_flags = 0;
         end else begin
            chk("R7", "no flush", int'(pkt_flush), 0);
         end
      end else begin
         m_lost++;
         chk("R10", "lost count", int'(lost_count), m_lost);
      end
   endtask

   task automatic ticks(int n, bit expiry);
      bit fl;
      @(negedge clk);
      etu_tick = 1'b1;
      for (int j = 1; j <= n; j++) begin
         @(negedge clk);
         if (j == n) etu_tick = 1'b0;
         fl = expiry && (j == n) && m_have;
         if (fl || j == n || j == n - 1)
            chk("R8", $sformatf("flush at tick %0d", j), int'(pkt_flush), int'(fl));
         else if (pkt_flush)
            chk("R8", $sformatf("early flush at tick %0d", j), 1, 0);
         if (fl) begin
            chk("R8", "timeout len", int'(pkt_len), exp_timeout_len(m_fill));
            chk("R9", "timeout flags", int'(pkt_flags), m_flags | 2);
            m_fill = 0; m_have = 0; m_flags = 0;
         end
      end
   endtask

   initial begin
      #(8 * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int n, fill_before, lost_before;
      void'($urandom(32'h5EED));
      idle(3);
      rst_n = 1'b1;
      idle(2);
      chk("R1", "reset phase", int'(phase), 0);
      chk("R1", "reset rx_enable", int'(rx_enable), 0);
      chk("R1", "reset rx_clear", int'(rx_clear), 1);
      chk("R1", "reset flush", int'(pkt_flush), 0);

      // short glitch on the reset pin
      card_rst_pin = 1'b1; idle(2); card_rst_pin = 1'b0; idle(12);
      chk("R2", "glitch phase", int'(phase), 0);
      chk("R2", "glitch restart", restarts, 0);

      // release reset
      card_rst_pin = 1'b1; idle(12);
      m_flags |= 1;
      chk("R3", "phase after release", int'(phase), 1);
      chk("R3", "restart pulses", restarts, 1);
      chk("R1", "rx_enable after release", int'(rx_enable), 1);

      // answer-to-reset bytes
      send_byte(8'h3B, 1);
      chk("R4", "phase in ATR", int'(phase), 2);
      n = 3 + int'($urandom % 4);
      for (int i = 0; i < n; i++) send_byte(8'($urandom), 1);

      // parser done: timing-change sequence
      @(negedge clk); atr_done = 1'b1;
      @(negedge clk); atr_done = 1'b0;
      chk("R5", "phase after done", int'(phase), 3);
      chk("R5", "step1 rx_enable", int'(rx_enable), 0);
      chk("R5", "step1 rx_clear", int'(rx_clear), 1);
      chk("R5", "step1 ratio_load", int'(ratio_load), 0);
      @(negedge clk);
      chk("R5", "step2 ratio_load", int'(ratio_load), 1);
      chk("R5", "step2 rx_enable", int'(rx_enable), 0);
      @(negedge clk);
      chk("R5", "step3 ratio_load", int'(ratio_load), 0);
      chk("R5", "step3 rx_enable", int'(rx_enable), 1);
      idle(1);

      // timer runs with the parser's waiting time; flags carry release + timeout
      ticks(WTA, 1);
      chk("R8", "phase after expiry", int'(phase), 3);

      // command bytes
      send_byte(8'hA0, 0);
      chk("R6", "phase in command", int'(phase), 4);

      // random fill with buffer gaps
      for (int i = 0; i < 130; i++) begin
         buf_avail = ($urandom % 8) != 0;
         send_byte(8'($urandom), 0);
      end
      buf_avail = 1'b1;
      ticks(WTA, 1);

      // drop with no packet open
      buf_avail = 1'b0;
      lost_before = m_lost;
      send_byte(8'h55, 0);
      chk("R10", "one drop", m_lost - lost_before, 1);
      buf_avail = 1'b1;

      // expiry with nothing pending
      ticks(WTA, 1);
      chk("R11", "phase after empty expiry", int'(phase), 3);

      // reload on each byte
      send_byte(8'h11, 0);
      ticks(WTA - 5, 0);
      send_byte(8'h22, 0);
      fill_before = m_fill;
      ticks(WTA - 5, 0);
      chk("R8", "fill kept during reload", m_fill, fill_before);
      ticks(5, 1);

      // leave a partial packet, then reset and release again
      send_byte(8'h33, 0);
      card_rst_pin = 1'b0; idle(12);
      chk("R1", "phase after pin low", int'(phase), 0);
      chk("R1", "rx_enable after pin low", int'(rx_enable), 0);
      chk("R1", "rx_clear after pin low", int'(rx_clear), 1);
      card_rst_pin = 1'b1; idle(12);
      m_flags |= 1;
      chk("R3", "second release restarts", restarts, 2);
      send_byte(8'h3F, 1);
      ticks(9600, 1);
      chk("R3", "phase after initial wait", int'(phase), 3);

      idle(3);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule